// File: doc/BRIEF.md
# Probe-Driven Best Next-Hop Table

This block is the routing memory of a switch that balances load hop by hop. Switches at the edge of the network send probes from time to time, and each probe travels toward the upstream tiers. A probe names the top-of-rack switch it came from and carries the worst link utilization seen so far on its path. For every destination, the table keeps one downstream port and the path utilization measured through that port. The block does not hold the full set of paths.

A parsed probe enters with its arrival port. The block raises the carried utilization to the utilization of the local link the probe arrived over. It then decides whether the probe should replace or refresh the entry for that destination. The rewritten probe is sent out one cycle later so that it can be replicated to upstream neighbours. A separate combinational lookup port gives the data path the best hop for a destination within the same cycle.

Top module: `best_hop_table`

## Requirements
- R1: After reset every entry is invalid, so a lookup of any destination returns lookupValid=0, and outProbeValid is 0.
- R2: One cycle after probeValid is sampled high, outProbeValid is 1. In that same cycle outProbeDest equals the probe's destination, and outProbeUtil equals the larger of the probe's carried utilization and linkUtil of its arrival port. Port p's utilization is the slice linkUtil[p*UTIL_W +: UTIL_W].
- R3: A probe for an invalid entry always writes it. The entry becomes valid, with the hop set to the arrival port and the utilization set to the rewritten path utilization from R2.
- R4: A probe that arrives on a port other than the stored hop replaces the hop and the utilization when its path utilization is strictly lower than the stored utilization.
- R5: A probe from another port whose path utilization is equal to or higher than the stored value leaves the entry unchanged.
- R6: A probe that arrives on the stored hop port always overwrites the stored utilization with its path utilization, whether that value is higher or lower.
- R7: lookupHop, lookupUtil and lookupValid reflect the entry for lookupDest combinationally, in the same cycle.
- R8: When a probe write and a lookup hit the same entry in one cycle, the lookup returns the value from before the write. The new value is visible after the clock edge.
- R9: A probe changes only the entry of its own destination. Every other entry keeps its hop, utilization and valid bit.
- R10: When no probe is presented in a cycle, outProbeValid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probeValid | input | 1 | A parsed probe is present |
| probeDest | input | DEST_W | Destination top-of-rack index carried by the probe |
| probeUtil | input | UTIL_W | Maximum path utilization carried by the probe |
| probePort | input | PORT_W | Port the probe arrived on |
| linkUtil | input | NUM_PORTS*UTIL_W | Local link utilization for each port, with port p in slice p |
| outProbeValid | output | 1 | The rewritten probe is ready for replication |
| outProbeDest | output | DEST_W | Destination of the forwarded probe |
| outProbeUtil | output | UTIL_W | Rewritten path utilization |
| lookupDest | input | DEST_W | Destination to look up for the data path |
| lookupHop | output | PORT_W | Best next-hop port |
| lookupUtil | output | UTIL_W | Path utilization of the best hop |
| lookupValid | output | 1 | The entry has been learned |

## Verification
The bench checks the tie, where an equal utilization from a different port must not move the hop. A strict-versus-loose comparison error would make the hop flip between ports. It drives a higher value on the stored port, which a design that only accepts improvements would ignore, leaving a stale low utilization in the entry. It sets the local link above the carried value and uses the extremes 0 and 255, so that dropping the max step or truncating the compare would show up in both the forwarded probe and the entry. It also makes a lookup collide with a write to the same entry, where a bypass would leak the new hop one cycle early. It then rechecks an entry that was not written, to catch a write that reaches the wrong index.

// File: rtl/best_hop_pkg.sv
package best_hop_pkg;

  // Strobes from the decision logic to the table datapath.
  typedef struct packed {
    logic wrEntry;   // commit the probe's path to the entry
    logic fwdProbe;  // launch the rewritten probe
  } hopStrobe_t;

endpackage

// File: rtl/best_hop_ctrl.sv
module best_hop_ctrl
  import best_hop_pkg::*;
#(
  parameter int UTIL_W = 8,
  parameter int PORT_W = 3
) (
  input  logic              probeValid,
  input  logic [PORT_W-1:0] probePort,
  input  logic              rdValid,
  input  logic [PORT_W-1:0] rdPort,
  input  logic [UTIL_W-1:0] rdUtil,
  input  logic [UTIL_W-1:0] pathUtil,
  output hopStrobe_t        strobe
);

  logic samePort;
  logic better;

  always_comb begin
    samePort = (probePort == rdPort);
    better   = (pathUtil < rdUtil);
    strobe.fwdProbe = probeValid;
    strobe.wrEntry  = 1'b0;
    if (probeValid) begin
      if (!rdValid)      strobe.wrEntry = 1'b1;  // first probe learned
      else if (samePort) strobe.wrEntry = 1'b1;  // refresh current hop
      else if (better)   strobe.wrEntry = 1'b1;  // strictly better path
    end
  end

endmodule

// File: rtl/best_hop_dp.sv
module best_hop_dp
  import best_hop_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DEST_W    = 6,
  parameter int UTIL_W    = 8,
  parameter int PORT_W    = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        probeValid,
  input  logic [DEST_W-1:0]           probeDest,
  input  logic [UTIL_W-1:0]           probeUtil,
  input  logic [PORT_W-1:0]           probePort,
  input  logic [NUM_PORTS*UTIL_W-1:0] linkUtil,
  input  hopStrobe_t                  strobe,
  output logic                        rdValid,
  output logic [PORT_W-1:0]           rdPort,
  output logic [UTIL_W-1:0]           rdUtil,
  output logic [UTIL_W-1:0]           pathUtil,
  output logic                        outProbeValid,
  output logic [DEST_W-1:0]           outProbeDest,
  output logic [UTIL_W-1:0]           outProbeUtil,
  input  logic [DEST_W-1:0]           lookupDest,
  output logic [PORT_W-1:0]           lookupHop,
  output logic [UTIL_W-1:0]           lookupUtil,
  output logic                        lookupValid
);

  localparam int DEPTH = 1 << DEST_W;

  logic              tblValid [DEPTH];
  logic [PORT_W-1:0] tblPort  [DEPTH];
  logic [UTIL_W-1:0] tblUtil  [DEPTH];

  // Unpack the per-port link utilization.
  logic [UTIL_W-1:0] linkArr [NUM_PORTS];
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_link
    assign linkArr[p] = linkUtil[p*UTIL_W +: UTIL_W];
  end

  logic [UTIL_W-1:0] arrivalLink;

  always_comb begin
    arrivalLink = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (probePort == PORT_W'(p)) arrivalLink = linkArr[p];
    end
    pathUtil = (arrivalLink > probeUtil) ? arrivalLink : probeUtil;
  end

  // Read of the entry that the probe addresses.
  assign rdValid = tblValid[probeDest];
  assign rdPort  = tblPort[probeDest];
  assign rdUtil  = tblUtil[probeDest];

  // Data-path lookup reads the registered table, so it sees the old value.
  assign lookupValid = tblValid[lookupDest];
  assign lookupHop   = tblPort[lookupDest];
  assign lookupUtil  = tblUtil[lookupDest];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        tblValid[i] <= 1'b0;
        tblPort[i]  <= '0;
        tblUtil[i]  <= '0;
      end
    end else if (strobe.wrEntry) begin
      tblValid[probeDest] <= 1'b1;
      tblPort[probeDest]  <= probePort;
      tblUtil[probeDest]  <= pathUtil;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outProbeValid <= 1'b0;
      outProbeDest  <= '0;
      outProbeUtil  <= '0;
    end else begin
      outProbeValid <= strobe.fwdProbe;
      if (strobe.fwdProbe) begin
        outProbeDest <= probeDest;
        outProbeUtil <= pathUtil;
      end
    end
  end

  // R2
  out_not_below_carried_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> (outProbeValid && outProbeUtil >= $past(probeUtil)));

  // R10
  no_spurious_probe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !probeValid |=> !outProbeValid);

  // R3
  first_probe_learns_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && !rdValid) |=> tblValid[$past(probeDest)]);

  // R6
  same_port_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && rdValid && probePort == rdPort)
      |=> tblUtil[$past(probeDest)] == $past(pathUtil));

  // R5
  worse_path_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && rdValid && probePort != rdPort && pathUtil >= rdUtil)
      |=> (tblPort[$past(probeDest)] == $past(rdPort)
           && tblUtil[$past(probeDest)] == $past(rdUtil)));

endmodule

// File: rtl/best_hop_table.sv
module best_hop_table
  import best_hop_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DEST_W    = 6,
  parameter int UTIL_W    = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        probeValid,
  input  logic [DEST_W-1:0]           probeDest,
  input  logic [UTIL_W-1:0]           probeUtil,
  input  logic [PORT_W-1:0]           probePort,
  input  logic [NUM_PORTS*UTIL_W-1:0] linkUtil,
  output logic                        outProbeValid,
  output logic [DEST_W-1:0]           outProbeDest,
  output logic [UTIL_W-1:0]           outProbeUtil,
  input  logic [DEST_W-1:0]           lookupDest,
  output logic [PORT_W-1:0]           lookupHop,
  output logic [UTIL_W-1:0]           lookupUtil,
  output logic                        lookupValid
);

  hopStrobe_t        strobe;
  logic              rdValid;
  logic [PORT_W-1:0] rdPort;
  logic [UTIL_W-1:0] rdUtil;
  logic [UTIL_W-1:0] pathUtil;

  best_hop_ctrl #(.UTIL_W(UTIL_W), .PORT_W(PORT_W)) uCtrl (
    .probeValid(probeValid),
    .probePort (probePort),
    .rdValid   (rdValid),
    .rdPort    (rdPort),
    .rdUtil    (rdUtil),
    .pathUtil  (pathUtil),
    .strobe    (strobe)
  );

  best_hop_dp #(
    .NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W), .UTIL_W(UTIL_W), .PORT_W(PORT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .probeValid   (probeValid),
    .probeDest    (probeDest),
    .probeUtil    (probeUtil),
    .probePort    (probePort),
    .linkUtil     (linkUtil),
    .strobe       (strobe),
    .rdValid      (rdValid),
    .rdPort       (rdPort),
    .rdUtil       (rdUtil),
    .pathUtil     (pathUtil),
    .outProbeValid(outProbeValid),
    .outProbeDest (outProbeDest),
    .outProbeUtil (outProbeUtil),
    .lookupDest   (lookupDest),
    .lookupHop    (lookupHop),
    .lookupUtil   (lookupUtil),
    .lookupValid  (lookupValid)
  );

endmodule

// File: tb/sim_best_hop_table.sv
`timescale 1ns/1ps
module sim_best_hop_table;

  localparam int NUM_PORTS = 8;
  localparam int DEST_W    = 6;
  localparam int UTIL_W    = 8;
  localparam int PORT_W    = 3;

  logic                        clk = 1'b0;
  logic                        rstN;
  logic                        probeValid;
  logic [DEST_W-1:0]           probeDest;
  logic [UTIL_W-1:0]           probeUtil;
  logic [PORT_W-1:0]           probePort;
  logic [NUM_PORTS*UTIL_W-1:0] linkUtil;
  logic                        outProbeValid;
  logic [DEST_W-1:0]           outProbeDest;
  logic [UTIL_W-1:0]           outProbeUtil;
  logic [DEST_W-1:0]           lookupDest;
  logic [PORT_W-1:0]           lookupHop;
  logic [UTIL_W-1:0]           lookupUtil;
  logic                        lookupValid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  best_hop_table #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W), .UTIL_W(UTIL_W)) u0 (
    .clk(clk), .rstN(rstN), .probeValid(probeValid), .probeDest(probeDest),
    .probeUtil(probeUtil), .probePort(probePort), .linkUtil(linkUtil),
    .outProbeValid(outProbeValid), .outProbeDest(outProbeDest),
    .outProbeUtil(outProbeUtil), .lookupDest(lookupDest), .lookupHop(lookupHop),
    .lookupUtil(lookupUtil), .lookupValid(lookupValid)
  );

  typedef struct packed {
    logic [7:0] dest;
    logic [7:0] util;
    logic [7:0] port;
    logic [7:0] link;
    logic [7:0] expHop;
    logic [7:0] expUtil;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'd5,  8'd50,  8'd2, 8'd10,  8'd2, 8'd50},   // R3 first learn
    '{8'd5,  8'd30,  8'd4, 8'd40,  8'd4, 8'd40},   // R4 better via link max
    '{8'd5,  8'd40,  8'd1, 8'd0,   8'd4, 8'd40},   // R5 tie keeps
    '{8'd5,  8'd90,  8'd1, 8'd0,   8'd4, 8'd40},   // R5 worse keeps
    '{8'd5,  8'd70,  8'd4, 8'd20,  8'd4, 8'd70},   // R6 same port higher
    '{8'd5,  8'd10,  8'd4, 8'd5,   8'd4, 8'd10},   // R6 same port lower
    '{8'd9,  8'd200, 8'd7, 8'd255, 8'd7, 8'd255},  // R3 top value
    '{8'd5,  8'd0,   8'd0, 8'd12,  8'd4, 8'd10},   // R5 link raises above
    '{8'd63, 8'd0,   8'd0, 8'd0,   8'd0, 8'd0},    // R3 last index, zero
    '{8'd9,  8'd254, 8'd3, 8'd0,   8'd3, 8'd254}   // R4 one below
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendProbe(input int d, input int u, input int p, input int l);
    @(negedge clk);
    probeValid = 1'b1;
    probeDest  = DEST_W'(d);
    probeUtil  = UTIL_W'(u);
    probePort  = PORT_W'(p);
    linkUtil   = '0;
    linkUtil[p*UTIL_W +: UTIL_W] = UTIL_W'(l);
    lookupDest = DEST_W'(d);
    @(posedge clk);
    #1;
    probeValid = 1'b0;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; probeValid = 1'b0; probeDest = '0; probeUtil = '0;
    probePort = '0; linkUtil = '0; lookupDest = '0;
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outProbeValid", 32'(outProbeValid), 0);
    lookupDest = 6'd5;  #0.5; check("R1 lookupValid d5", 32'(lookupValid), 0);
    lookupDest = 6'd63; #0.5; check("R1 lookupValid d63", 32'(lookupValid), 0);

    for (int i = 0; i < NVEC; i++) begin
      int mx;
      mx = (VECS[i].link > VECS[i].util) ? VECS[i].link : VECS[i].util;
      sendProbe(VECS[i].dest, VECS[i].util, VECS[i].port, VECS[i].link);
      check($sformatf("R2 out valid v%0d", i), 32'(outProbeValid), 1);
      check($sformatf("R2 out dest v%0d", i), 32'(outProbeDest), 32'(VECS[i].dest));
      check($sformatf("R2 out util v%0d", i), 32'(outProbeUtil), 32'(mx));
      check($sformatf("R7 valid v%0d", i), 32'(lookupValid), 1);
      check($sformatf("R3-6 hop v%0d", i), 32'(lookupHop), 32'(VECS[i].expHop));
      check($sformatf("R3-6 util v%0d", i), 32'(lookupUtil), 32'(VECS[i].expUtil));
    end

    // R10 idle cycle
    @(posedge clk); #1;
    check("R10 idle outProbeValid", 32'(outProbeValid), 0);

    // R9 untouched entries keep their values
    lookupDest = 6'd5; #0.5;
    check("R9 d5 hop", 32'(lookupHop), 4);
    check("R9 d5 util", 32'(lookupUtil), 10);
    lookupDest = 6'd20; #0.5;
    check("R9 d20 invalid", 32'(lookupValid), 0);

    // R8 same-cycle write and lookup: old value before edge, new after
    @(negedge clk);
    probeValid = 1'b1; probeDest = 6'd9; probeUtil = 8'd1; probePort = 3'd6;
    linkUtil = '0; lookupDest = 6'd9;
    #1;
    check("R8 pre-write hop", 32'(lookupHop), 3);
    check("R8 pre-write util", 32'(lookupUtil), 254);
    @(posedge clk); #1;
    probeValid = 1'b0;
    check("R8 post-write hop", 32'(lookupHop), 6);
    check("R8 post-write util", 32'(lookupUtil), 1);

    // R7 combinational lookup switch within one cycle
    lookupDest = 6'd63; #0.5;
    check("R7 d63 valid", 32'(lookupValid), 1);
    check("R7 d63 hop", 32'(lookupHop), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule